// File: doc/BRIEF.md
# Lock-Aware Victim Way Selector

This block chooses which way of an 8-way set-associative cache a miss should refill. Ways may be locked down one line at a time, and each requester may be limited to a subset of the ways. For every request the cache controller presents the lock bits of all ways at the addressed index and the requester's allowed-way mask. The block returns a way number and a lock decision one clock later.

A miss takes a way that is allowed and unlocked. Among such ways it follows a rotating pointer kept for each index. A lock request is refused when granting it would leave the requester with no unlocked way at that index. The triggering load still completes, but the line stays unlocked. If a miss finds every allowed way locked, it takes the lowest allowed way, and the block tells the controller to clear that way's lock.

Each of these two abnormal events raises its own sticky error flag. Software clears a flag by writing one to it, and each flag has its own interrupt enable. Tag storage and data movement belong to the surrounding controller.

Top module: `lock_victim_sel`

## Requirements
- R1: Every cycle in which `req_valid` is high produces exactly one cycle of `rsp_valid` after the next rising clock edge, and a cycle without a request produces none.
- R2: A miss never picks a way that is locked or outside the effective mask while at least one way is both allowed and unlocked.
- R3: Each index keeps its own rotating pointer, reset to 0. A normal miss takes the first available way at or after the pointer, wrapping from way 7 back to way 0, and moves the pointer to the chosen way plus one. Other indexes are not affected.
- R4: An all-zero `allow_mask` is treated as all ways allowed, for misses and for lock requests alike.
- R5: A lock request on `req_way` is granted (`rsp_set_lock`=1, `rsp_way`=`req_way`) only if at least one way other than the target remains allowed and unlocked. Otherwise it is refused (`rsp_set_lock`=0) and `lock_err` is set. A lock request never moves a pointer.
- R6: A miss that finds no allowed unlocked way returns the lowest-numbered allowed way with `rsp_clr_lock`=1, sets `miss_err`, and leaves that index's pointer unchanged.
- R7: `lock_err` and `miss_err` stay set until cleared by writing 1 to `clr_err[0]` (lock) or `clr_err[1]` (miss). Clearing one flag leaves the other alone, and a new event in the same cycle as a clear wins.
- R8: `irq` is high exactly when (`lock_err` and `lock_irq_en`) or (`miss_err` and `miss_irq_en`).
- R9: After synchronous active-low reset, `rsp_valid`, `rsp_set_lock`, `rsp_clr_lock`, `lock_err`, `miss_err` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_lock | input | 1 | 1 = lock request on `req_way`, 0 = miss needing a victim |
| req_index | input | IDX_W | Cache index of the request |
| req_way | input | WAY_W | Target way of a lock request |
| allow_mask | input | NUM_WAYS | Requester's allowed ways (all zero = all ways) |
| way_locked | input | NUM_WAYS | Current lock bits of the ways at `req_index` |
| clr_err | input | 2 | Write-1-to-clear: bit 0 lock error, bit 1 miss error |
| lock_irq_en | input | 1 | Interrupt enable for `lock_err` |
| miss_irq_en | input | 1 | Interrupt enable for `miss_err` |
| rsp_valid | output | 1 | Response valid |
| rsp_way | output | WAY_W | Chosen victim way, or the lock target |
| rsp_set_lock | output | 1 | Lock request granted: lock `rsp_way` |
| rsp_clr_lock | output | 1 | Forced victim: clear the lock of `rsp_way` |
| lock_err | output | 1 | Sticky flag: refused lock request |
| miss_err | output | 1 | Sticky flag: miss found every allowed way locked |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `NUM_WAYS`=8 and `NUM_SETS`=4. With four indexes, pointers can be driven into separate states and shown not to disturb each other. Eight ways let a pointer run past way 7 and wrap to way 0 under a narrow mask. The small index count also keeps all pointer states short to reach, so one run covers the wrap, the forced-victim case that leaves the pointer alone, and refused locks under a zero mask.

// File: rtl/lock_victim_pkg.sv
// Package: shared types for the lock-aware victim selector.
// Assumes nothing beyond IEEE 1800-2017.
package lock_victim_pkg;

    // Kind of action taken for one request
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_FILL   = 2'd1,
        ACT_FORCE  = 2'd2,
        ACT_LOCK   = 2'd3
    } act_e;

    // Bit positions inside the write-1-to-clear error vector
    localparam int ERR_LOCK_BIT = 0;
    localparam int ERR_MISS_BIT = 1;

endpackage

// File: rtl/lvs_rr_pick.sv
// Module: lvs_rr_pick
// Combinational rotating-priority picker. Returns the first set bit of
// avail at or after ptr, wrapping around. Assumes N is a power of two.
module lvs_rr_pick #(
    parameter int N     = 8,
    localparam int WAY_W = $clog2(N)
) (
    input  logic [N-1:0]     avail,
    input  logic [WAY_W-1:0] ptr,
    output logic             found,
    output logic [WAY_W-1:0] pick
);
    // Scan from the far end so the nearest candidate after ptr wins
    always_comb begin
        logic [WAY_W-1:0] idx;
        found = |avail;
        pick  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            idx = ptr + WAY_W'(i);
            if (avail[idx]) pick = idx;
        end
    end
endmodule

// File: rtl/lvs_lock_guard.sv
// Module: lvs_lock_guard
// Decides whether a lock on the target way may be granted: at least one
// other way must remain allowed and unlocked. Assumes avail is already
// the effective mask with locked ways removed.
module lvs_lock_guard #(
    parameter int N     = 8,
    localparam int WAY_W = $clog2(N)
) (
    input  logic [N-1:0]     avail,
    input  logic [WAY_W-1:0] target,
    output logic             grant
);
    logic [N-1:0] target_oh;

    // Leave the target out and see whether anything is left
    always_comb begin
        target_oh = {{(N-1){1'b0}}, 1'b1} << target;
        grant     = |(avail & ~target_oh);
    end
endmodule

// File: rtl/lvs_ptr_table.sv
// Module: lvs_ptr_table
// One rotating pointer per cache index, with an asynchronous read and a
// synchronous write. Pointers reset to way 0 under synchronous active-low
// reset.
module lvs_ptr_table #(
    parameter int N     = 8,
    parameter int SETS  = 64,
    localparam int WAY_W = $clog2(N),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_index,
    output logic [WAY_W-1:0] rd_ptr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [WAY_W-1:0] wr_ptr
);
    logic [WAY_W-1:0] ptr_q [SETS];

    // Read the pointer of the requested index
    assign rd_ptr = ptr_q[rd_index];

    // Reset all pointers or advance the one written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (wr_en) begin
            ptr_q[wr_index] <= wr_ptr;
        end
    end
endmodule

// File: rtl/lock_victim_sel.sv
// Module: lock_victim_sel (top)
// Chooses a victim way for misses and decides on lock requests. It
// respects locked ways and the requester's allowed-way mask, keeps one
// allowed way unlocked per index, and keeps two sticky error flags with
// interrupt enables. Assumes way_locked belongs to req_index in the same
// cycle and that NUM_WAYS and NUM_SETS are powers of two (NUM_SETS >= 2).
module lock_victim_sel #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 64,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int IDX_W = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_is_lock,
    input  logic [IDX_W-1:0]    req_index,
    input  logic [WAY_W-1:0]    req_way,
    input  logic [NUM_WAYS-1:0] allow_mask,
    input  logic [NUM_WAYS-1:0] way_locked,
    input  logic [1:0]          clr_err,
    input  logic                lock_irq_en,
    input  logic                miss_irq_en,
    output logic                rsp_valid,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                rsp_set_lock,
    output logic                rsp_clr_lock,
    output logic                lock_err,
    output logic                miss_err,
    output logic                irq
);
    import lock_victim_pkg::*;

    logic [NUM_WAYS-1:0] eff_mask;
    logic [NUM_WAYS-1:0] avail;
    logic [WAY_W-1:0]    cur_ptr;
    logic [WAY_W-1:0]    rr_way;
    logic                rr_found;
    logic                lock_ok;
    logic [WAY_W-1:0]    low_way;
    act_e                act;
    logic [WAY_W-1:0]    nxt_way;
    logic                ptr_wr;

    // Zero mask means every way; drop locked ways to get the candidates
    always_comb begin
        eff_mask = (allow_mask == '0) ? '1 : allow_mask;
        avail    = eff_mask & ~way_locked;
    end

    // Lowest-numbered allowed way, used when every allowed way is locked
    always_comb begin
        low_way = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (eff_mask[i]) low_way = WAY_W'(i);
        end
    end

    lvs_ptr_table #(.N(NUM_WAYS), .SETS(NUM_SETS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_index (req_index),
        .rd_ptr   (cur_ptr),
        .wr_en    (ptr_wr),
        .wr_index (req_index),
        .wr_ptr   (WAY_W'(rr_way + 1'b1))
    );

    lvs_rr_pick #(.N(NUM_WAYS)) u_pick (
        .avail (avail),
        .ptr   (cur_ptr),
        .found (rr_found),
        .pick  (rr_way)
    );

    lvs_lock_guard #(.N(NUM_WAYS)) u_guard (
        .avail  (avail),
        .target (req_way),
        .grant  (lock_ok)
    );

    // Classify the request and choose the way to report
    always_comb begin
        act     = ACT_NONE;
        nxt_way = '0;
        if (req_valid && req_is_lock) begin
            act     = ACT_LOCK;
            nxt_way = req_way;
        end else if (req_valid && rr_found) begin
            act     = ACT_FILL;
            nxt_way = rr_way;
        end else if (req_valid) begin
            act     = ACT_FORCE;
            nxt_way = low_way;
        end
        ptr_wr = (act == ACT_FILL);
    end

    // Register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_way      <= '0;
            rsp_set_lock <= 1'b0;
            rsp_clr_lock <= 1'b0;
        end else begin
            rsp_valid    <= (act != ACT_NONE);
            rsp_way      <= nxt_way;
            rsp_set_lock <= (act == ACT_LOCK) && lock_ok;
            rsp_clr_lock <= (act == ACT_FORCE);
        end
    end

    // Sticky error flags: a new event beats a write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_err <= 1'b0;
            miss_err <= 1'b0;
        end else begin
            lock_err <= ((act == ACT_LOCK) && !lock_ok)
                        || (lock_err && !clr_err[ERR_LOCK_BIT]);
            miss_err <= (act == ACT_FORCE)
                        || (miss_err && !clr_err[ERR_MISS_BIT]);
        end
    end

    // Interrupt from the enabled flags
    assign irq = (lock_err && lock_irq_en) || (miss_err && miss_irq_en);

endmodule

// File: rtl/lock_victim_sel_chk.sv
// Module: lock_victim_sel_chk
// Assertion checker bound to lock_victim_sel. It records the request
// inputs of each cycle and checks the registered response against them.
module lock_victim_sel_chk #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 64,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int IDX_W = $clog2(NUM_SETS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_is_lock,
    input logic [IDX_W-1:0]    req_index,
    input logic [WAY_W-1:0]    req_way,
    input logic [NUM_WAYS-1:0] allow_mask,
    input logic [NUM_WAYS-1:0] way_locked,
    input logic [1:0]          clr_err,
    input logic                lock_irq_en,
    input logic                miss_irq_en,
    input logic                rsp_valid,
    input logic [WAY_W-1:0]    rsp_way,
    input logic                rsp_set_lock,
    input logic                rsp_clr_lock,
    input logic                lock_err,
    input logic                miss_err,
    input logic                irq
);
    logic [NUM_WAYS-1:0] prev_eff;
    logic [NUM_WAYS-1:0] prev_locked;
    logic                prev_is_lock;
    logic [WAY_W-1:0]    prev_way;
    logic [IDX_W-1:0]    prev_index;
    logic [NUM_WAYS-1:0] rsp_oh;

    // Capture the request seen at each edge
    always_ff @(posedge clk) begin
        prev_eff     <= (allow_mask == '0) ? '1 : allow_mask;
        prev_locked  <= way_locked;
        prev_is_lock <= req_is_lock;
        prev_way     <= req_way;
        prev_index   <= req_index;
    end

    assign rsp_oh = {{(NUM_WAYS-1){1'b0}}, 1'b1} << rsp_way;

    a_r1_one_rsp_per_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2 and R4: a normal victim is allowed and unlocked
    a_r2_victim_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !prev_is_lock && !rsp_clr_lock)
        |-> ((prev_eff & ~prev_locked & rsp_oh) != '0));
    a_r5_grant_leaves_one: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_set_lock |-> (((prev_eff & ~prev_locked & ~rsp_oh) != '0)
                          && rsp_way == prev_way && prev_is_lock));
    a_r6_force_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_clr_lock |-> (((prev_eff & ~prev_locked) == '0)
                          && ((prev_eff & rsp_oh) != '0) && miss_err));
    a_r7_lock_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_err && !clr_err[0]) |=> lock_err);
    a_r7_miss_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_err && !clr_err[1]) |=> miss_err);
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((lock_err && lock_irq_en) || (miss_err && miss_irq_en)));

    // Index is recorded for debug views; keep it referenced
    a_r3_index_known: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$isunknown(prev_index));
endmodule

bind lock_victim_sel lock_victim_sel_chk #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_lock  (req_is_lock),
    .req_index    (req_index),
    .req_way      (req_way),
    .allow_mask   (allow_mask),
    .way_locked   (way_locked),
    .clr_err      (clr_err),
    .lock_irq_en  (lock_irq_en),
    .miss_irq_en  (miss_irq_en),
    .rsp_valid    (rsp_valid),
    .rsp_way      (rsp_way),
    .rsp_set_lock (rsp_set_lock),
    .rsp_clr_lock (rsp_clr_lock),
    .lock_err     (lock_err),
    .miss_err     (miss_err),
    .irq          (irq)
);

// File: tb/lock_victim_sel_bench.sv
// Directed bench for lock_victim_sel: one task per scenario.
module lock_victim_sel_bench;
    localparam int NW = 8;
    localparam int NS = 4;
    localparam int WW = $clog2(NW);
    localparam int IW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_is_lock = 1'b0;
    logic [IW-1:0] req_index = '0;
    logic [WW-1:0] req_way = '0;
    logic [NW-1:0] allow_mask = '0;
    logic [NW-1:0] way_locked = '0;
    logic [1:0]    clr_err = '0;
    logic          lock_irq_en = 1'b0;
    logic          miss_irq_en = 1'b0;
    logic          rsp_valid;
    logic [WW-1:0] rsp_way;
    logic          rsp_set_lock;
    logic          rsp_clr_lock;
    logic          lock_err;
    logic          miss_err;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    lock_victim_sel #(.NUM_WAYS(NW), .NUM_SETS(NS)) u_lock_victim_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_is_lock(req_is_lock), .req_index(req_index), .req_way(req_way),
        .allow_mask(allow_mask), .way_locked(way_locked), .clr_err(clr_err),
        .lock_irq_en(lock_irq_en), .miss_irq_en(miss_irq_en),
        .rsp_valid(rsp_valid), .rsp_way(rsp_way), .rsp_set_lock(rsp_set_lock),
        .rsp_clr_lock(rsp_clr_lock), .lock_err(lock_err), .miss_err(miss_err),
        .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one request at a negedge, sample the response at the next one
    task automatic issue(input bit is_lock, input int idx, input int way,
                         input int mask, input int locked);
        req_valid   = 1'b1;
        req_is_lock = is_lock;
        req_index   = IW'(idx);
        req_way     = WW'(way);
        allow_mask  = NW'(mask);
        way_locked  = NW'(locked);
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    task automatic miss_expect(input string tag, input int idx, input int mask,
                               input int locked, input int exp_way, input int exp_clr);
        issue(1'b0, idx, 0, mask, locked);
        check({tag, " rsp_valid"}, rsp_valid, 1);
        check({tag, " way"}, rsp_way, exp_way);
        check({tag, " clr_lock"}, rsp_clr_lock, exp_clr);
        check({tag, " set_lock"}, rsp_set_lock, 0);
    endtask

    task automatic t_reset();
        check("R9 rsp_valid", rsp_valid, 0);
        check("R9 lock_err", lock_err, 0);
        check("R9 miss_err", miss_err, 0);
        check("R9 irq", irq, 0);
        @(negedge clk);
        check("R1 idle no rsp", rsp_valid, 0);
    endtask

    task automatic t_round_robin();
        miss_expect("R3 rr idx0 a", 0, 'hFF, 'h00, 0, 0);
        miss_expect("R3 rr idx0 b", 0, 'hFF, 'h00, 1, 0);
        miss_expect("R3 rr idx0 c", 0, 'hFF, 'h00, 2, 0);
        miss_expect("R3 rr idx0 d", 0, 'hFF, 'h00, 3, 0);
        @(negedge clk);
        check("R1 rsp drops", rsp_valid, 0);
    endtask

    task automatic t_skip_locked();
        miss_expect("R2 skip idx1 a", 1, 'hFF, 'h06, 0, 0);
        miss_expect("R2 skip idx1 b", 1, 'hFF, 'h06, 3, 0);
    endtask

    task automatic t_partition();
        miss_expect("R2 mask idx2 a", 2, 'hF0, 'h00, 4, 0);
        miss_expect("R2 mask idx2 b", 2, 'hF0, 'h00, 5, 0);
        // pointer of index 2 is now 6: ways 6,7 not allowed, wrap to 0
        miss_expect("R3 wrap idx2", 2, 'h03, 'h00, 0, 0);
    endtask

    task automatic t_zero_mask();
        miss_expect("R4 zero mask idx3", 3, 'h00, 'hFE, 0, 0);
        issue(1'b1, 3, 7, 'h00, 'h7F);
        check("R4 zero mask lock refused", rsp_set_lock, 0);
        check("R5 refused sets lock_err", lock_err, 1);
        clr_err = 2'b01;
        @(negedge clk);
        clr_err = 2'b00;
        check("R7 w1c lock_err", lock_err, 0);
    endtask

    task automatic t_lock_rules();
        issue(1'b1, 1, 1, 'h03, 'h00);
        check("R5 grant", rsp_set_lock, 1);
        check("R5 grant way", rsp_way, 1);
        check("R5 grant no err", lock_err, 0);
        issue(1'b1, 1, 0, 'h03, 'h02);
        check("R5 last way rsp", rsp_valid, 1);
        check("R5 last way refused", rsp_set_lock, 0);
        check("R5 last way lock_err", lock_err, 1);
        check("R5 miss_err untouched", miss_err, 0);
        check("R8 irq masked", irq, 0);
        lock_irq_en = 1'b1;
        #1;
        check("R8 irq enabled", irq, 1);
        // a new refusal in the same cycle as a clear keeps the flag
        clr_err = 2'b01;
        issue(1'b1, 1, 0, 'h03, 'h02);
        clr_err = 2'b00;
        check("R7 set beats clear", lock_err, 1);
        @(negedge clk);
        check("R7 sticky", lock_err, 1);
        miss_expect("R3 lock kept ptr idx1", 1, 'hFF, 'h00, 4, 0);
    endtask

    task automatic t_forced();
        miss_expect("R6 forced idx0", 0, 'h0C, 'h0C, 2, 1);
        check("R6 miss_err", miss_err, 1);
        check("R8 irq miss masked", irq, 1);
        lock_irq_en = 1'b0;
        #1;
        check("R8 irq miss only masked", irq, 0);
        miss_irq_en = 1'b1;
        #1;
        check("R8 irq miss enabled", irq, 1);
        miss_expect("R6 ptr unchanged idx0", 0, 'hFF, 'h00, 4, 0);
        clr_err = 2'b10;
        @(negedge clk);
        clr_err = 2'b00;
        check("R7 w1c miss_err", miss_err, 0);
        check("R7 lock_err kept", lock_err, 1);
        check("R8 irq off", irq, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_skip_locked();
        t_partition();
        t_zero_mask();
        t_lock_rules();
        t_forced();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule